// File: doc/BRIEF.md
# Half-to-Single Precision Widener

This block takes a 16-bit IEEE-754 binary16 bit pattern and produces the 32-bit binary32 pattern that holds exactly the same value. Every binary16 value fits in binary32, so the block never rounds. Sign, infinities and NaN payloads carry straight across. Binary16 subnormals become binary32 normals.

A word enters with a valid strobe. One clock edge later it leaves as a widened word with its own valid strobe, and every code takes the same latency. A subnormal input is renormalized in one combinational pass. A priority search finds the leading set fraction bit, and a single shift moves the fraction into place. There is no iterative loop.

Top module: `half_widen_top`

## Requirements
- R1: Output bit 31 equals input bit 15 for every code.
- R2: An input with exponent field [14:10] zero and fraction [9:0] zero gives an output whose bits 30:0 are all zero.
- R3: An input with exponent field zero and a nonzero fraction gives an output exponent [30:23] of 113 minus s, where s is the number of left shifts that bring the first set fraction bit up to bit 10. The output fraction [22:13] is the fraction after those s shifts, keeping its low 10 bits.
- R4: An input exponent field of 5'h1F gives an output exponent of 8'hFF, with input bits 9:0 copied unchanged into output bits 22:13.
- R5: An input exponent field from 1 to 30 gives an output exponent equal to that field plus 112, with input bits 9:0 placed at output bits 22:13.
- R6: Output bits 12:0 are zero for every converted code.
- R7: When the input valid is high, the output valid is high one cycle later and carries the converted word. When the input valid is low, the output valid is low one cycle later and the output word keeps its previous value.
- R8: A synchronous reset clears the output valid and the output word to zero, even while the input valid is high.
- R9: Narrowing any output back to binary16 returns the original bits for every non-NaN code, and returns a NaN for every NaN code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inVld | input | 1 | Input word valid |
| inHalf | input | 16 | binary16 bit pattern |
| outVld | output | 1 | Output word valid, one cycle after inVld |
| outWord | output | 32 | binary32 bit pattern |

## Verification
The assertions assume that inHalf is stable and known in any cycle where inVld is high. They also assume that reset is held for at least one clock edge before the first valid word. Past-value checks rely on a converted word appearing exactly one edge after its strobe. The bench changes inputs only on the falling clock edge and holds each word for a full cycle. Reset is released only after two edges.

// File: rtl/half_widen_pkg.sv
package half_widen_pkg;
  localparam int HALF_W     = 16;
  localparam int HALF_EXP_W = 5;
  localparam int HALF_FRC_W = 10;
  localparam int HALF_BIAS  = 15;
  localparam int SGL_W      = 32;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRC_W  = 23;
  localparam int SGL_BIAS   = 127;
  localparam int EXP_ADJ    = SGL_BIAS - HALF_BIAS;      // 112
  localparam int SUB_BASE   = EXP_ADJ + 1;               // 113
  localparam int PAD_W      = SGL_FRC_W - HALF_FRC_W;    // 13
  localparam int LZ_W       = $clog2(HALF_FRC_W + 1);

  typedef struct packed {
    logic load;
    logic clear;
  } cvtCtl_t;
endpackage

// File: rtl/half_widen_lzc.sv
module half_widen_lzc #(
  parameter int WIDTH = 10,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] vec,
  output logic [CW-1:0]    cnt
);
  // Scan upward; the highest set bit is written last and wins.
  always_comb begin
    cnt = CW'(WIDTH);
    for (int i = 0; i < WIDTH; i++) begin
      if (vec[i]) cnt = CW'(WIDTH - 1 - i);
    end
  end
endmodule

// File: rtl/half_widen_ctrl.sv
module half_widen_ctrl
  import half_widen_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inVld,
  output cvtCtl_t ctl,
  output logic    outVld
);
  always_comb begin
    ctl.clear = rst;
    ctl.load  = inVld & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outVld <= 1'b0;
    else     outVld <= inVld;
  end

  // R7
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst) inVld |=> outVld);
  // R7
  vld_drop_chk: assert property (@(posedge clk) disable iff (rst) !inVld |=> !outVld);
endmodule

// File: rtl/half_widen_dp.sv
module half_widen_dp
  import half_widen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  cvtCtl_t           ctl,
  input  logic [HALF_W-1:0] inHalf,
  output logic [SGL_W-1:0]  outWord
);
  logic                  sgn;
  logic [HALF_EXP_W-1:0] hExp;
  logic [HALF_FRC_W-1:0] hFrac;
  logic [LZ_W-1:0]       lzCnt;
  logic [LZ_W-1:0]       shiftAmt;
  logic [HALF_FRC_W-1:0] normFrac;
  logic [SGL_EXP_W-1:0]  subExp;
  logic [SGL_EXP_W-1:0]  nrmExp;
  logic [SGL_W-1:0]      wideWord;

  assign sgn   = inHalf[HALF_W-1];
  assign hExp  = inHalf[HALF_W-2 -: HALF_EXP_W];
  assign hFrac = inHalf[HALF_FRC_W-1:0];

  half_widen_lzc #(.WIDTH(HALF_FRC_W)) uLzc (
    .vec (hFrac),
    .cnt (lzCnt)
  );

  always_comb begin
    shiftAmt = lzCnt + LZ_W'(1);
    normFrac = hFrac << shiftAmt;
    subExp   = SGL_EXP_W'(SUB_BASE) - SGL_EXP_W'(shiftAmt);
    nrmExp   = SGL_EXP_W'(hExp) + SGL_EXP_W'(EXP_ADJ);
    if (hExp == '0 && hFrac == '0)
      wideWord = {sgn, {(SGL_W-1){1'b0}}};
    else if (hExp == '0)
      wideWord = {sgn, subExp, normFrac, {PAD_W{1'b0}}};
    else if (hExp == '1)
      wideWord = {sgn, {SGL_EXP_W{1'b1}}, hFrac, {PAD_W{1'b0}}};
    else
      wideWord = {sgn, nrmExp, hFrac, {PAD_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (ctl.clear)     outWord <= '0;
    else if (ctl.load) outWord <= wideWord;
  end

  // R1
  sign_move_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.load |=> outWord[SGL_W-1] == $past(inHalf[HALF_W-1]));
  // R2
  zero_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.load |=> ((outWord[SGL_W-2:0] == '0) == ($past(inHalf[HALF_W-2:0]) == '0)));
  // R4
  special_exp_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.load |=> ((outWord[SGL_W-2 -: SGL_EXP_W] == '1) ==
                  ($past(inHalf[HALF_W-2 -: HALF_EXP_W]) == '1)));
  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.load |=> $stable(outWord));
endmodule

// File: rtl/half_widen_top.sv
module half_widen_top
  import half_widen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inVld,
  input  logic [HALF_W-1:0] inHalf,
  output logic              outVld,
  output logic [SGL_W-1:0]  outWord
);
  cvtCtl_t ctl;

  half_widen_ctrl uCtrl (
    .clk    (clk),
    .rst    (rst),
    .inVld  (inVld),
    .ctl    (ctl),
    .outVld (outVld)
  );

  half_widen_dp uDp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .inHalf  (inHalf),
    .outWord (outWord)
  );
endmodule

// File: tb/tb_half_widen_top.sv
`timescale 1ns/1ps
module tb_half_widen_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inVld = 1'b0;
  logic [15:0] inHalf = '0;
  logic        outVld;
  logic [31:0] outWord;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  half_widen_top dut (.clk(clk), .rst(rst), .inVld(inVld), .inHalf(inHalf),
                      .outVld(outVld), .outWord(outWord));

  localparam logic [47:0] VEC [15] = '{
    {16'h0000, 32'h0000_0000}, {16'h8000, 32'h8000_0000},
    {16'h3C00, 32'h3F80_0000}, {16'hBC00, 32'hBF80_0000},
    {16'h7BFF, 32'h477F_E000}, {16'h0400, 32'h3880_0000},
    {16'h0001, 32'h3380_0000}, {16'h8001, 32'hB380_0000},
    {16'h03FF, 32'h387F_C000}, {16'h0200, 32'h3800_0000},
    {16'h7C00, 32'h7F80_0000}, {16'hFC00, 32'hFF80_0000},
    {16'h7E00, 32'h7FC0_0000}, {16'h7C01, 32'h7F80_2000},
    {16'h3555, 32'h3EAA_A000}
  };

  // Reference widening, written from the requirements with an explicit shift loop.
  function automatic logic [31:0] refWiden(input logic [15:0] h);
    logic [4:0]  e;
    logic [10:0] f;
    int          s;
    e = h[14:10];
    f = {1'b0, h[9:0]};
    if (e == 5'd0 && f == 11'd0) return {h[15], 31'd0};
    if (e == 5'd0) begin
      s = 0;
      while (f[10] == 1'b0) begin
        f = f << 1;
        s++;
      end
      return {h[15], 8'(113 - s), f[9:0], 13'd0};
    end
    if (e == 5'h1F) return {h[15], 8'hFF, h[9:0], 13'd0};
    return {h[15], 8'(e + 112), h[9:0], 13'd0};
  endfunction

  // Narrowing of exactly representable values (R9 round trip).
  function automatic logic [15:0] narrow(input logic [31:0] w);
    logic [7:0]  e;
    logic [23:0] m;
    logic [15:0] r;
    e = w[30:23];
    m = {1'b1, w[22:0]};
    if (e == 8'hFF) begin
      r = {1'b0, 5'h1F, w[22:13]};
      if (w[22:0] != 0 && r[9:0] == 0) r[0] = 1'b1;
      return {w[31], r[14:0]};
    end
    if (e == 8'd0) return {w[31], 15'd0};
    if (e >= 8'd113) return {w[31], 5'(e - 112), w[22:13]};
    r = 16'(m >> (126 - e));
    return {w[31], r[14:0]};
  endfunction

  function automatic string tagOf(input logic [15:0] h);
    if (h[14:10] == 5'd0 && h[9:0] == 0) return "R2";
    if (h[14:10] == 5'd0) return "R3";
    if (h[14:10] == 5'h1F) return "R4";
    return "R5";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic convert(input logic [15:0] h);
    inHalf = h;
    inVld  = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (2) @(negedge clk);
    // R8 reset state
    check("R8", {31'd0, outVld}, 32'd0);
    check("R8", outWord, 32'd0);
    rst = 1'b0;

    // Table walk: R1 sign, R2..R5 by class, R6 low zeros, R7 one-cycle valid
    foreach (VEC[i]) begin
      convert(VEC[i][47:32]);
      check("R7", {31'd0, outVld}, 32'd1);
      check(tagOf(VEC[i][47:32]), outWord, VEC[i][31:0]);
      check("R1", {31'd0, outWord[31]}, {31'd0, VEC[i][47]});
    end

    // R7 hold: strobe low, data changes, word must stay
    convert(16'h4248);
    held = outWord;
    check("R5", held, 32'h4049_0000);
    inVld = 1'b0;
    inHalf = 16'hFBFF;
    @(negedge clk);
    check("R7", {31'd0, outVld}, 32'd0);
    check("R7", outWord, held);

    // R8 reset while valid is high
    inVld = 1'b1;
    inHalf = 16'h3C00;
    rst = 1'b1;
    @(negedge clk);
    check("R8", {31'd0, outVld}, 32'd0);
    check("R8", outWord, 32'd0);
    rst = 1'b0;

    // Full sweep: R1..R6 against the model, R9 round trip
    for (int c = 0; c < 65536; c++) begin
      convert(16'(c));
      check(tagOf(16'(c)), outWord, refWiden(16'(c)));
      check("R6", {19'd0, outWord[12:0]}, 32'd0);
      if (c[14:10] == 5'h1F && c[9:0] != 0)
        check("R9", {31'd0, (narrow(outWord)[14:10] == 5'h1F && narrow(outWord)[9:0] != 0)}, 32'd1);
      else
        check("R9", {16'd0, narrow(outWord)}, c);
    end
    inVld = 1'b0;
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule